// File: doc/BRIEF.md
# Bit-Serial PHY Tuning Writer

This block programs tuning parameters inside a transceiver that only exposes one narrow control register. A tuning field of up to `DATA_W` bits cannot be written in one go. It goes in one bit at a time. For each bit, the writer places an internal address in the upper byte of the register and the bit value in bit 7. It then pulses the strobe bit that belongs to the selected port. Bits are sent least significant first. The internal address advances by one for every bit.

A client raises `reqValid` for one cycle with a port index, a start address, a data word and a bit count. The block then keeps `busy` high while the sequence runs and pulses `done` when it has finished. Each of the three strobe phases (setup, high, low) lasts a programmable number of clock cycles. A target model is included. It records every strobed bit into a per-port parameter array of 256 entries, and that array can be read back through a combinational read port.

Top module: `phy_tune_writer`

## Requirements
- R1: After reset, `ctrlReg` is all zero, `busy` and `done` are low, and every entry of every port's parameter array reads 0.
- R2: While `busy` is low, a `reqValid` cycle with `reqLen` other than 0 is accepted, and `busy` is high in the next cycle.
- R3: While `busy` is high, `reqValid` is ignored: it produces no strobe and no array write, and the running sequence carries on unchanged.
- R4: A request with `reqLen` equal to 0 is refused: `busy` stays low, `done` does not pulse, and no array entry changes.
- R5: For bit i of a request, `ctrlReg[15:8]` holds (start + i) mod 256 and `ctrlReg[7]` holds data bit i (taken as 0 when i is at or above `DATA_W`) whenever the strobe rises.
- R6: During a request to port n, only strobe bit 2*n of `ctrlReg` ever goes high, and it pulses exactly once per bit. Bits 0, 2, 4 and 6 belong to ports 0 to 3, and at most one of them is high at a time.
- R7: With H = max(`holdCycles`, 1) latched at acceptance, the strobe stays high for H cycles, and from one strobe fall to the next strobe rise is 2*H cycles (H low, then H setup).
- R8: `done` is high for exactly one cycle. That cycle comes after the last strobe has fallen, and `busy` is already low in it.
- R9: When `CLEAR_FIRST` is 1, `ctrlReg` reads all zero in the second cycle after acceptance. Between requests, `ctrlReg` keeps the last address and data bit, with all strobes low.
- R10: On each rising edge of port n's strobe, the target stores `ctrlReg[7]` into entry `ctrlReg[15:8]` of port n's array. `rdBit` returns entry `rdAddr` of port `rdPort`. Writes to one port leave the other ports' arrays unchanged.
- R11: When a sequence passes address 255, the address wraps to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request strobe, one cycle |
| reqPort | input | PORT_W | Target port index |
| reqAddr | input | 8 | Internal start address |
| reqData | input | DATA_W | Value to write, sent LSB first |
| reqLen | input | LEN_W | Number of bits to send |
| holdCycles | input | PHASE_W | Cycles per strobe phase (0 is taken as 1) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| ctrlReg | output | 16 | Image of the shared control register |
| rdPort | input | PORT_W | Target model read port select |
| rdAddr | input | 8 | Target model read address |
| rdBit | output | 1 | Stored parameter bit |

## Verification
The bench builds the block with four ports, a 32-bit data word, a 4-bit phase counter and `CLEAR_FIRST` set to 1. With four ports, each of the four strobe positions in the register is used. The 32-bit word allows a full-length transfer of every bit. The 4-bit counter allows hold values of 0 through 3 to be tried. With clear-first enabled, the zeroing step is observed on every request. The start addresses are chosen so that one sequence wraps past address 255.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int CTRL_W   = 16;
  localparam int ADDR_W   = 8;
  localparam int ADDR_LSB = 8;
  localparam int DATA_BIT = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLR,
    ST_SETUP,
    ST_HIGH,
    ST_LOW
  } seqState_t;

  typedef struct packed {
    logic load;
    logic clearAll;
    logic loadBit;
    logic strobeSet;
    logic strobeClr;
    logic shift;
  } dpCmd_t;
endpackage

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
#(
  parameter int LEN_W       = 6,
  parameter int PHASE_W     = 4,
  parameter bit CLEAR_FIRST = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [LEN_W-1:0]   reqLen,
  input  logic [PHASE_W-1:0] holdCycles,
  output dpCmd_t             cmd,
  output logic               busy,
  output logic               done
);
  seqState_t state, nxtState;
  logic [PHASE_W-1:0] phaseCnt, holdLat, holdLim;
  logic [LEN_W-1:0]   bitCnt, lenLat;
  logic               doneQ, accept, phaseEnd, lastBit;

  assign holdLim  = (holdLat == '0) ? '0 : holdLat - 1'b1;
  assign phaseEnd = (phaseCnt == holdLim);
  assign lastBit  = (bitCnt == lenLat - 1'b1);
  assign accept   = (state == ST_IDLE) && reqValid && (reqLen != '0);

  always_comb begin
    nxtState = state;
    case (state)
      ST_IDLE:  if (accept) nxtState = CLEAR_FIRST ? ST_CLR : ST_SETUP;
      ST_CLR:   nxtState = ST_SETUP;
      ST_SETUP: if (phaseEnd) nxtState = ST_HIGH;
      ST_HIGH:  if (phaseEnd) nxtState = ST_LOW;
      ST_LOW:   if (phaseEnd) nxtState = lastBit ? ST_IDLE : ST_SETUP;
      default:  nxtState = ST_IDLE;
    endcase
  end

  always_comb begin
    cmd           = '0;
    cmd.load      = accept;
    cmd.clearAll  = (state == ST_CLR);
    cmd.loadBit   = (state == ST_SETUP) && (phaseCnt == '0);
    cmd.strobeSet = (state == ST_HIGH) && (phaseCnt == '0);
    cmd.strobeClr = (state == ST_LOW) && (phaseCnt == '0);
    cmd.shift     = (state == ST_LOW) && phaseEnd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phaseCnt <= '0;
      holdLat  <= '0;
      lenLat   <= '0;
      bitCnt   <= '0;
      doneQ    <= 1'b0;
    end else begin
      state <= nxtState;
      doneQ <= (state == ST_LOW) && phaseEnd && lastBit;
      if (accept) begin
        holdLat  <= holdCycles;
        lenLat   <= reqLen;
        bitCnt   <= '0;
        phaseCnt <= '0;
      end else if (state != nxtState) begin
        phaseCnt <= '0;
      end else if (state != ST_IDLE) begin
        phaseCnt <= phaseCnt + 1'b1;
      end
      if ((state == ST_LOW) && phaseEnd) bitCnt <= bitCnt + 1'b1;
    end
  end

  assign busy = (state != ST_IDLE);
  assign done = doneQ;

  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && reqValid && reqLen != '0) |=> busy);
  // R4
  zero_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && reqValid && reqLen == '0) |=> (!busy && !done));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
endmodule

// File: rtl/ptw_datapath.sv
module ptw_datapath
  import ptw_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int DATA_W    = 32,
  localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCmd_t            cmd,
  input  logic [PORT_W-1:0] reqPort,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  output logic [CTRL_W-1:0] ctrlReg
);
  logic [ADDR_W-1:0]    curAddr, addrF;
  logic [DATA_W-1:0]    shiftData;
  logic [PORT_W-1:0]    portSel;
  logic                 dataF;
  logic [NUM_PORTS-1:0] strobeF;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr   <= '0;
      shiftData <= '0;
      portSel   <= '0;
      addrF     <= '0;
      dataF     <= 1'b0;
    end else begin
      if (cmd.load) begin
        curAddr   <= reqAddr;
        shiftData <= reqData;
        portSel   <= reqPort;
      end else if (cmd.shift) begin
        curAddr   <= curAddr + 1'b1;
        shiftData <= shiftData >> 1;
      end
      if (cmd.clearAll) begin
        addrF <= '0;
        dataF <= 1'b0;
      end else if (cmd.loadBit) begin
        addrF <= curAddr;
        dataF <= shiftData[0];
      end
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_strobe
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        strobeF[p] <= 1'b0;
      end else if (cmd.clearAll) begin
        strobeF[p] <= 1'b0;
      end else if (portSel == PORT_W'(p)) begin
        if (cmd.loadBit || cmd.strobeClr) strobeF[p] <= 1'b0;
        else if (cmd.strobeSet)           strobeF[p] <= 1'b1;
      end
    end
  end

  always_comb begin
    ctrlReg = '0;
    ctrlReg[ADDR_LSB +: ADDR_W] = addrF;
    ctrlReg[DATA_BIT] = dataF;
    for (int p = 0; p < NUM_PORTS; p++) ctrlReg[2*p] = strobeF[p];
  end

  // R6
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobeF));
  // R5
  field_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|strobeF) |-> $stable({addrF, dataF}));
endmodule

// File: rtl/ptw_target.sv
module ptw_target
  import ptw_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int ENTRIES  = 1 << ADDR_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_PORTS-1:0] strobeVec,
  input  logic [ADDR_W-1:0]    bitAddr,
  input  logic                 bitVal,
  input  logic [PORT_W-1:0]    rdPort,
  input  logic [ADDR_W-1:0]    rdAddr,
  output logic                 rdBit
);
  logic [ENTRIES-1:0]   paramArr [NUM_PORTS];
  logic [NUM_PORTS-1:0] prevStb;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        paramArr[p] <= '0;
        prevStb[p]  <= 1'b0;
      end else begin
        prevStb[p] <= strobeVec[p];
        if (strobeVec[p] && !prevStb[p]) paramArr[p][bitAddr] <= bitVal;
      end
    end
  end

  assign rdBit = paramArr[rdPort][rdAddr];
endmodule

// File: rtl/phy_tune_writer.sv
module phy_tune_writer
  import ptw_pkg::*;
#(
  parameter int NUM_PORTS   = 4,
  parameter int DATA_W      = 32,
  parameter int PHASE_W     = 4,
  parameter bit CLEAR_FIRST = 1'b1,
  localparam int PORT_W     = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int LEN_W      = $clog2(DATA_W + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [PORT_W-1:0]  reqPort,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [DATA_W-1:0]  reqData,
  input  logic [LEN_W-1:0]   reqLen,
  input  logic [PHASE_W-1:0] holdCycles,
  output logic               busy,
  output logic               done,
  output logic [CTRL_W-1:0]  ctrlReg,
  input  logic [PORT_W-1:0]  rdPort,
  input  logic [ADDR_W-1:0]  rdAddr,
  output logic               rdBit
);
  dpCmd_t               cmd;
  logic [NUM_PORTS-1:0] strobeVec;

  ptw_ctrl #(
    .LEN_W(LEN_W), .PHASE_W(PHASE_W), .CLEAR_FIRST(CLEAR_FIRST)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqLen(reqLen),
    .holdCycles(holdCycles), .cmd(cmd), .busy(busy), .done(done)
  );

  ptw_datapath #(
    .NUM_PORTS(NUM_PORTS), .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .reqPort(reqPort),
    .reqAddr(reqAddr), .reqData(reqData), .ctrlReg(ctrlReg)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_tap
    assign strobeVec[p] = ctrlReg[2*p];
  end

  ptw_target #(
    .NUM_PORTS(NUM_PORTS)
  ) u_tgt (
    .clk(clk), .rstN(rstN), .strobeVec(strobeVec),
    .bitAddr(ctrlReg[ADDR_LSB +: ADDR_W]), .bitVal(ctrlReg[DATA_BIT]),
    .rdPort(rdPort), .rdAddr(rdAddr), .rdBit(rdBit)
  );
endmodule

// File: tb/phy_tune_writer_tb.sv
module phy_tune_writer_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqPort = '0;
  logic [7:0]  reqAddr = '0;
  logic [31:0] reqData = '0;
  logic [5:0]  reqLen = '0;
  logic [3:0]  holdCycles = '0;
  logic        busy, done, rdBit;
  logic [15:0] ctrlReg;
  logic [1:0]  rdPort = '0;
  logic [7:0]  rdAddr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_tune_writer #(
    .NUM_PORTS(4), .DATA_W(32), .PHASE_W(4), .CLEAR_FIRST(1'b1)
  ) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqPort(reqPort),
    .reqAddr(reqAddr), .reqData(reqData), .reqLen(reqLen),
    .holdCycles(holdCycles), .busy(busy), .done(done), .ctrlReg(ctrlReg),
    .rdPort(rdPort), .rdAddr(rdAddr), .rdBit(rdBit)
  );

  typedef struct {
    logic [1:0] port;
    logic [7:0] addr;
    logic       bitv;
  } expItem_t;

  expItem_t expQ[$];
  int total = 0, bad = 0, cycle = 0, expHold = 1;
  int lastRise = 0, lastFall = 0;
  bit haveFall = 0, finished = 0;
  logic [3:0] stbNow, prevStb = '0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) cycle++;

  // scoreboard monitor
  always @(negedge clk) begin
    stbNow = {ctrlReg[6], ctrlReg[4], ctrlReg[2], ctrlReg[0]};
    if (rstN) begin
      if ((stbNow & ~prevStb) != 0) begin
        if (expQ.size() == 0) begin
          check(0, "R3 unexpected strobe", {28'd0, stbNow}, 0);
        end else begin
          expItem_t e;
          e = expQ.pop_front();
          check(stbNow == (4'b1 << e.port), "R6 strobe position", {28'd0, stbNow}, {28'd0, 4'b1 << e.port});
          check(ctrlReg[15:8] == e.addr, "R5 address field", ctrlReg[15:8], e.addr);
          check(ctrlReg[7] == e.bitv, "R5 data bit", ctrlReg[7], e.bitv);
          if (haveFall) check(cycle - lastFall == 2*expHold, "R7 low+setup length", cycle - lastFall, 2*expHold);
        end
        lastRise = cycle;
      end
      if ((prevStb & ~stbNow) != 0) begin
        check(cycle - lastRise == expHold, "R7 high length", cycle - lastRise, expHold);
        lastFall = cycle;
        haveFall = 1;
      end
    end
    prevStb = stbNow;
  end

  task automatic startWrite(input logic [1:0] p, input logic [7:0] a, input logic [31:0] d,
                            input int len, input int hold);
    @(negedge clk);
    for (int i = 0; i < len; i++) begin
      expItem_t e;
      e.port = p;
      e.addr = 8'((a + i) % 256);
      e.bitv = (i < 32) ? d[i] : 1'b0;
      expQ.push_back(e);
    end
    expHold = (hold == 0) ? 1 : hold;
    haveFall = 0;
    reqValid = 1'b1; reqPort = p; reqAddr = a; reqData = d;
    reqLen = 6'(len); holdCycles = 4'(hold);
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    check(busy == 1'b1, "R2 busy after accept", busy, 1);
    @(negedge clk);
    check(ctrlReg == 16'h0, "R9 clear before sequence", ctrlReg, 0);
  endtask

  task automatic waitDone();
    int n = 0;
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
    end
    check(done == 1'b1, "R8 done seen", done, 1);
    check(busy == 1'b0, "R8 busy low with done", busy, 0);
    check(expQ.size() == 0, "R8 all strobes before done", expQ.size(), 0);
    check(ctrlReg[6] == 0 && ctrlReg[4] == 0 && ctrlReg[2] == 0 && ctrlReg[0] == 0,
          "R8 strobe low at done", ctrlReg, 0);
    @(negedge clk);
    check(done == 1'b0, "R8 done one cycle", done, 0);
  endtask

  task automatic readBit(input logic [1:0] p, input logic [7:0] a, output logic v);
    rdPort = p; rdAddr = a;
    #1;
    v = rdBit;
  endtask

  task automatic checkArr(input logic [1:0] p, input logic [7:0] a, input logic [31:0] d,
                          input int len, input string tag);
    for (int i = 0; i < len; i++) begin
      logic v;
      readBit(p, 8'((a + i) % 256), v);
      check(v == d[i], tag, v, d[i]);
    end
  endtask

  initial begin
    logic v;
    repeat (3) @(negedge clk);
    check(ctrlReg == 16'h0, "R1 ctrlReg reset", ctrlReg, 0);
    check(busy == 0 && done == 0, "R1 busy/done reset", {busy, done}, 0);
    rstN = 1'b1;
    @(negedge clk);
    readBit(2'd0, 8'h20, v);
    check(v == 1'b0, "R1 array reset", v, 0);

    // 5-bit field on port 0
    startWrite(2'd0, 8'h20, 32'h14, 5, 2);
    waitDone();
    checkArr(2'd0, 8'h20, 32'h14, 5, "R10 readback p0");
    check(ctrlReg[15:8] == 8'h24 && ctrlReg[7] == 1'b1, "R9 retained fields", ctrlReg, 16'h2480);

    // 2-bit field on port 1, hold 1
    startWrite(2'd1, 8'h2a, 32'h2, 2, 1);
    waitDone();
    checkArr(2'd1, 8'h2a, 32'h2, 2, "R10 readback p1");

    // request while busy is refused
    startWrite(2'd2, 8'h40, 32'hF, 4, 3);
    @(negedge clk);
    reqValid = 1'b1; reqPort = 2'd3; reqAddr = 8'h80; reqData = 32'hFF; reqLen = 6'd8;
    @(negedge clk);
    reqValid = 1'b0;
    check(busy == 1'b1, "R3 busy kept", busy, 1);
    waitDone();
    checkArr(2'd2, 8'h40, 32'hF, 4, "R10 readback p2");
    checkArr(2'd3, 8'h80, 32'h0, 8, "R3 refused writes absent");

    // zero length refused
    @(negedge clk);
    reqValid = 1'b1; reqPort = 2'd0; reqAddr = 8'h50; reqData = 32'hFF; reqLen = 6'd0;
    @(negedge clk);
    reqValid = 1'b0;
    check(busy == 1'b0, "R4 zero length not accepted", busy, 0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(done == 1'b0 && busy == 1'b0, "R4 no done", {busy, done}, 0);
    end
    readBit(2'd0, 8'h50, v);
    check(v == 1'b0, "R4 array unchanged", v, 0);

    // address wrap
    startWrite(2'd3, 8'hFE, 32'hB, 4, 1);
    waitDone();
    checkArr(2'd3, 8'hFE, 32'hB, 4, "R11 wrap readback");

    // hold of zero acts as one
    startWrite(2'd1, 8'h10, 32'h5, 3, 0);
    waitDone();
    checkArr(2'd1, 8'h10, 32'h5, 3, "R7 hold0 readback");

    // full 32-bit word
    startWrite(2'd0, 8'h30, 32'hDEADBEEF, 32, 1);
    waitDone();
    checkArr(2'd0, 8'h30, 32'hDEADBEEF, 32, "R5 32-bit readback");

    // overwrite and isolation
    startWrite(2'd0, 8'h20, 32'h0B, 5, 2);
    waitDone();
    checkArr(2'd0, 8'h20, 32'h0B, 5, "R10 overwrite");
    checkArr(2'd1, 8'h2a, 32'h2, 2, "R10 other port untouched");
    readBit(2'd2, 8'h20, v);
    check(v == 1'b0, "R10 port isolation", v, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog R8 actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule